// File: doc/BRIEF.md
# Machine Check Error Logging Bank

This block is one error-logging bank in a processor's machine-check unit. A cache or bus unit hands it error events. Each event carries five things: a severity (correctable or uncorrectable), a flag saying processor context is corrupt, an error code, the physical address of the faulting access, and a qualifier that marks prefetch or speculative accesses. An event may also report that both halves of one sector failed in the same access.

The bank keeps three software-visible registers: a control register of per-code exception enables, a status record and an address record. Each incoming event passes through priority-based logging rules, which decide whether it replaces the current record. Every error after the first sets a sticky overflow flag. Logging and exception signalling are decided separately: an enabled, uncorrectable demand error produces a one-cycle exception request, while a bank with every enable cleared still records uncorrectable errors.

A status write from software wins over an error that arrives in the same cycle. That error is held for one cycle and then logged.

Top module: `mce_log_bank`

## Requirements
- R1: After reset the control, status and address registers read zero and `mce_req_o` is low.
- R2: The first event into an empty record sets the valid flag (status bit 63) and leaves the overflow flag (bit 62) clear. Any event that arrives while valid is set sets overflow.
- R3: Once overflow is set, it stays set through every later event until software writes the status register.
- R4: If the record holds an uncorrectable (bit 61) demand error, later events leave the code (bits 15:0), the flags and the address register unchanged, while overflow still gets set.
- R5: A correctable event replaces an earlier correctable record, updating both code and address, and never raises `mce_req_o`.
- R6: The exception enable for an event is control bit `err_code_i[2:0]`. An uncorrectable demand event whose enable is zero is logged with valid and uncorrected set, and `mce_req_o` stays low.
- R7: The address register holds the address presented together with the event that was logged, and not the address of any event that was rejected.
- R8: An event with `err_dual_i` set that lands in an empty record sets both valid and overflow.
- R9: An uncorrectable speculative event is logged with uncorrected, context-corrupt (bit 57) and speculative-origin (bit 56) set, and raises no exception. A correctable event cannot replace that record. A later uncorrectable demand event does replace it (code, address, speculative bit cleared), and it raises `mce_req_o` if enabled.
- R10: A status write loads the written flags and code, and it takes priority over an event in the same cycle. That event is logged in the following cycle.
- R11: `mce_req_o` is high for exactly the one cycle after an enabled uncorrectable demand event is logged.
- R12: With `reg_we_i` high, `reg_sel_i` 0 selects control, 1 selects status and 2 selects address. Read data is combinational on `reg_sel_i` and zero-extended.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| err_valid_i | input | 1 | Error event present this cycle |
| err_uc_i | input | 1 | Event is uncorrectable |
| err_pcc_i | input | 1 | Processor context corrupt |
| err_spec_i | input | 1 | Event came from a prefetch or speculative access |
| err_dual_i | input | 1 | Both sector halves failed in this access |
| err_code_i | input | CODE_W | Error code |
| err_addr_i | input | ADDR_W | Physical address of the faulting access |
| reg_we_i | input | 1 | Register write strobe |
| reg_sel_i | input | 2 | Register select |
| reg_wdata_i | input | 64 | Register write data |
| reg_rdata_o | output | 64 | Register read data |
| mce_req_o | output | 1 | Machine-check exception request pulse |

## Verification
The logging rules are driven with event sequences whose outcomes differ. A run of correctable events separates replacement from locking and shows overflow persisting. Correctable and uncorrectable events after an uncorrectable demand record show that the record is frozen. A speculative uncorrectable event followed first by a correctable event and then by a demand event shows that only a demand error may displace a deferred record. Cleared, single-bit and full control masks separate logging from exception gating. A status write and an event in the same cycle show the write winning and the event arriving one cycle later.

// File: rtl/mce_bank_pkg.sv
package mce_bank_pkg;
  localparam int DATA_W   = 64;
  localparam int ST_VAL   = 63;
  localparam int ST_OVR   = 62;
  localparam int ST_UC    = 61;
  localparam int ST_PCC   = 57;
  localparam int ST_SPEC  = 56;

  typedef enum logic [1:0] {
    SEL_CTL  = 2'd0,
    SEL_STAT = 2'd1,
    SEL_ADDR = 2'd2
  } reg_sel_e;
endpackage

// File: rtl/mce_ev_hold.sv
module mce_ev_hold #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         hold_i,
  input  logic         in_v_i,
  input  logic [W-1:0] in_d_i,
  output logic         out_v_o,
  output logic [W-1:0] out_d_o
);
  logic         v_q;
  logic [W-1:0] d_q;

  // captures one event while a status write blocks logging; consumed the next free cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v_q <= 1'b0;
      d_q <= '0;
    end else if (hold_i) begin
      if (!v_q && in_v_i) begin
        v_q <= 1'b1;
        d_q <= in_d_i;
      end
    end else begin
      v_q <= 1'b0;
    end
  end

  assign out_v_o = v_q;
  assign out_d_o = d_q;
endmodule

// File: rtl/mce_bank_core.sv
module mce_bank_core
  import mce_bank_pkg::*;
#(
  parameter int ADDR_W = 48,
  parameter int CODE_W = 16,
  parameter int CTL_W  = 8,
  localparam int EV_W  = 4 + CODE_W + ADDR_W,
  localparam int IDX_W = (CTL_W > 1) ? $clog2(CTL_W) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ev_v_i,
  input  logic [EV_W-1:0]   ev_d_i,
  input  logic              pd_v_i,
  input  logic [EV_W-1:0]   pd_d_i,
  input  logic              ctl_we_i,
  input  logic              stat_we_i,
  input  logic              addr_we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [CTL_W-1:0]  ctl_o,
  output logic [DATA_W-1:0] stat_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              mce_o
);
  typedef struct packed {
    logic              val;
    logic              ovr;
    logic              uc;
    logic              pcc;
    logic              spec;
    logic [CODE_W-1:0] code;
    logic [ADDR_W-1:0] addr;
  } rec_t;

  rec_t             rec_q, rec_a, rec_b, rec_d;
  logic [CTL_W-1:0] ctl_q;
  logic             mce_q, mce_d;

  function automatic rec_t step(rec_t s, logic v, logic [EV_W-1:0] d);
    rec_t n;
    logic uc, pcc, spec, dual, take;
    n = s;
    {uc, pcc, spec, dual} = d[EV_W-1 -: 4];
    // uncorrectable demand record is frozen; deferred speculative one yields to demand uc
    take = !s.val || !s.uc || (s.spec && uc && !spec);
    if (v) begin
      if (s.val || dual) n.ovr = 1'b1;
      if (take) begin
        n.val  = 1'b1;
        n.uc   = uc;
        n.pcc  = pcc;
        n.spec = uc & spec;
        n.code = d[ADDR_W +: CODE_W];
        n.addr = d[ADDR_W-1:0];
      end
    end
    return n;
  endfunction

  function automatic logic fire(logic v, logic [EV_W-1:0] d, logic [CTL_W-1:0] ctl);
    logic [IDX_W-1:0] idx;
    idx = d[ADDR_W +: IDX_W];
    return v && d[EV_W-1] && !d[EV_W-3] && ctl[idx];
  endfunction

  always_comb begin
    rec_a = step(rec_q, pd_v_i, pd_d_i);
    rec_b = step(rec_a, ev_v_i, ev_d_i);
    rec_d = rec_b;
    mce_d = fire(pd_v_i, pd_d_i, ctl_q) || fire(ev_v_i, ev_d_i, ctl_q);
    if (stat_we_i) begin
      rec_d      = rec_q;
      rec_d.val  = wdata_i[ST_VAL];
      rec_d.ovr  = wdata_i[ST_OVR];
      rec_d.uc   = wdata_i[ST_UC];
      rec_d.pcc  = wdata_i[ST_PCC];
      rec_d.spec = wdata_i[ST_SPEC];
      rec_d.code = wdata_i[CODE_W-1:0];
      mce_d      = 1'b0;
    end
    if (addr_we_i) rec_d.addr = wdata_i[ADDR_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rec_q <= '0;
      ctl_q <= '0;
      mce_q <= 1'b0;
    end else begin
      rec_q <= rec_d;
      mce_q <= mce_d;
      if (ctl_we_i) ctl_q <= wdata_i[CTL_W-1:0];
    end
  end

  always_comb begin
    stat_o                = '0;
    stat_o[ST_VAL]        = rec_q.val;
    stat_o[ST_OVR]        = rec_q.ovr;
    stat_o[ST_UC]         = rec_q.uc;
    stat_o[ST_PCC]        = rec_q.pcc;
    stat_o[ST_SPEC]       = rec_q.spec;
    stat_o[CODE_W-1:0]    = rec_q.code;
  end

  assign ctl_o  = ctl_q;
  assign addr_o = rec_q.addr;
  assign mce_o  = mce_q;

  logic unused_ok;
  assign unused_ok = ^{wdata_i[60:58], wdata_i[55:CODE_W]};

  // R2
  a_r2_overflow_on_repeat: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_v_i && !stat_we_i && rec_q.val) |=> rec_q.ovr);
  // R3
  a_r3_overflow_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rec_q.ovr && !stat_we_i) |=> rec_q.ovr);
  // R4
  a_r4_uc_record_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rec_q.val && rec_q.uc && !rec_q.spec && !stat_we_i && !addr_we_i)
      |=> ($stable(rec_q.code) && $stable(rec_q.addr) && rec_q.uc));
  // R5
  a_r5_mce_needs_uc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mce_q |-> $past((ev_v_i && ev_d_i[EV_W-1]) || (pd_v_i && pd_d_i[EV_W-1])));
  // R6
  a_r6_no_mce_when_disabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mce_q |-> $past(ctl_q != '0));
  // R11
  a_r11_mce_follows_event: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mce_q |-> $past(ev_v_i || pd_v_i));
endmodule

// File: rtl/mce_reg_rd.sv
module mce_reg_rd
  import mce_bank_pkg::*;
#(
  parameter int ADDR_W = 48,
  parameter int CTL_W  = 8
) (
  input  logic [1:0]        sel_i,
  input  logic [CTL_W-1:0]  ctl_i,
  input  logic [DATA_W-1:0] stat_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [DATA_W-1:0] rdata_o
);
  always_comb begin
    unique case (sel_i)
      SEL_CTL:  rdata_o = {{(DATA_W-CTL_W){1'b0}}, ctl_i};
      SEL_STAT: rdata_o = stat_i;
      SEL_ADDR: rdata_o = {{(DATA_W-ADDR_W){1'b0}}, addr_i};
      default:  rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/mce_log_bank.sv
module mce_log_bank
  import mce_bank_pkg::*;
#(
  parameter int ADDR_W = 48,
  parameter int CODE_W = 16,
  parameter int CTL_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              err_valid_i,
  input  logic              err_uc_i,
  input  logic              err_pcc_i,
  input  logic              err_spec_i,
  input  logic              err_dual_i,
  input  logic [CODE_W-1:0] err_code_i,
  input  logic [ADDR_W-1:0] err_addr_i,
  input  logic              reg_we_i,
  input  logic [1:0]        reg_sel_i,
  input  logic [63:0]       reg_wdata_i,
  output logic [63:0]       reg_rdata_o,
  output logic              mce_req_o
);
  localparam int EV_W = 4 + CODE_W + ADDR_W;

  logic [EV_W-1:0]   ev_d, pd_d;
  logic              pd_v, ctl_we, stat_we, addr_we, ev_live;
  logic [CTL_W-1:0]  ctl;
  logic [DATA_W-1:0] stat;
  logic [ADDR_W-1:0] addr;

  assign ev_d    = {err_uc_i, err_pcc_i, err_spec_i, err_dual_i, err_code_i, err_addr_i};
  assign ctl_we  = reg_we_i && (reg_sel_i == SEL_CTL);
  assign stat_we = reg_we_i && (reg_sel_i == SEL_STAT);
  assign addr_we = reg_we_i && (reg_sel_i == SEL_ADDR);
  assign ev_live = err_valid_i && !stat_we;

  mce_ev_hold #(.W(EV_W)) u_hold (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .hold_i  (stat_we),
    .in_v_i  (err_valid_i),
    .in_d_i  (ev_d),
    .out_v_o (pd_v),
    .out_d_o (pd_d)
  );

  mce_bank_core #(.ADDR_W(ADDR_W), .CODE_W(CODE_W), .CTL_W(CTL_W)) u_core (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ev_v_i    (ev_live),
    .ev_d_i    (ev_d),
    .pd_v_i    (pd_v && !stat_we),
    .pd_d_i    (pd_d),
    .ctl_we_i  (ctl_we),
    .stat_we_i (stat_we),
    .addr_we_i (addr_we),
    .wdata_i   (reg_wdata_i),
    .ctl_o     (ctl),
    .stat_o    (stat),
    .addr_o    (addr),
    .mce_o     (mce_req_o)
  );

  mce_reg_rd #(.ADDR_W(ADDR_W), .CTL_W(CTL_W)) u_rd (
    .sel_i   (reg_sel_i),
    .ctl_i   (ctl),
    .stat_i  (stat),
    .addr_i  (addr),
    .rdata_o (reg_rdata_o)
  );

  // R10
  a_r10_write_blocks_mce: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_we |=> !mce_req_o);
endmodule

// File: tb/sim_mce_log_bank.sv
module sim_mce_log_bank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        err_valid = 0, err_uc = 0, err_pcc = 0, err_spec = 0, err_dual = 0;
  logic [15:0] err_code = '0;
  logic [47:0] err_addr = '0;
  logic        reg_we = 0;
  logic [1:0]  reg_sel = '0;
  logic [63:0] reg_wdata = '0;
  logic [63:0] reg_rdata;
  logic        mce_req;
  int          n_chk = 0, n_fail = 0;
  bit          done = 0;

  always #2 clk = ~clk;

  mce_log_bank u0 (
    .clk_i(clk), .rst_ni(rst_n), .err_valid_i(err_valid), .err_uc_i(err_uc),
    .err_pcc_i(err_pcc), .err_spec_i(err_spec), .err_dual_i(err_dual),
    .err_code_i(err_code), .err_addr_i(err_addr), .reg_we_i(reg_we),
    .reg_sel_i(reg_sel), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .mce_req_o(mce_req)
  );

  function automatic logic [63:0] mk(logic v, logic o, logic u, logic p, logic s, logic [15:0] c);
    return {v, o, u, 3'b000, p, s, 40'h0, c};
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic ev(input logic u, p, s, d, input logic [15:0] c, input logic [47:0] a);
    @(negedge clk);
    err_uc = u; err_pcc = p; err_spec = s; err_dual = d; err_code = c; err_addr = a;
    err_valid = 1;
    @(negedge clk);
    err_valid = 0;
  endtask

  task automatic wr(input logic [1:0] sel, input logic [63:0] data);
    @(negedge clk);
    reg_sel = sel; reg_wdata = data; reg_we = 1;
    @(negedge clk);
    reg_we = 0;
  endtask

  task automatic rd(input logic [1:0] sel, output logic [63:0] d);
    reg_sel = sel;
    #0.5;
    d = reg_rdata;
  endtask

  task automatic t_reset();
    logic [63:0] d;
    rd(0, d); chk("R1 ctl", d, 0);
    rd(1, d); chk("R1 stat", d, 0);
    rd(2, d); chk("R1 addr", d, 0);
    chk("R1 mce", 64'(mce_req), 0);
    wr(0, 64'h1FF); rd(0, d); chk("R12 ctl readback", d, 64'hFF);
    wr(2, 64'hABCD); rd(2, d); chk("R12 addr readback", d, 64'hABCD);
    wr(0, 0);
  endtask

  task automatic t_corr();
    logic [63:0] d;
    wr(1, 0);
    ev(0, 0, 0, 0, 16'h0011, 48'h1000);
    rd(1, d); chk("R2 first", d, mk(1, 0, 0, 0, 0, 16'h11));
    rd(2, d); chk("R7 addr first", d, 64'h1000);
    chk("R5 no mce", 64'(mce_req), 0);
    ev(0, 0, 0, 0, 16'h0022, 48'h2000);
    rd(1, d); chk("R2 R5 second", d, mk(1, 1, 0, 0, 0, 16'h22));
    rd(2, d); chk("R5 addr replaced", d, 64'h2000);
    ev(0, 0, 0, 0, 16'h0033, 48'h3000);
    rd(1, d); chk("R3 third", d, mk(1, 1, 0, 0, 0, 16'h33));
    wr(1, 0);
    rd(1, d); chk("R10 clear", d, 0);
  endtask

  task automatic t_uclock();
    logic [63:0] d;
    wr(0, 64'hFF); wr(1, 0);
    ev(1, 1, 0, 0, 16'h0041, 48'hA000);
    chk("R11 mce high", 64'(mce_req), 1);
    rd(1, d); chk("R4 uc logged", d, mk(1, 0, 1, 1, 0, 16'h41));
    @(negedge clk); chk("R11 mce one cycle", 64'(mce_req), 0);
    ev(0, 0, 0, 0, 16'h0052, 48'hB000);
    rd(1, d); chk("R4 corr blocked", d, mk(1, 1, 1, 1, 0, 16'h41));
    rd(2, d); chk("R4 R7 addr kept", d, 64'hA000);
    ev(1, 0, 0, 0, 16'h0063, 48'hC000);
    rd(1, d); chk("R4 uc blocked", d, mk(1, 1, 1, 1, 0, 16'h41));
    rd(2, d); chk("R7 addr not rejected event", d, 64'hA000);
  endtask

  task automatic t_disabled();
    logic [63:0] d;
    wr(0, 0); wr(1, 0);
    ev(1, 0, 0, 0, 16'h0005, 48'hD000);
    chk("R6 no mce", 64'(mce_req), 0);
    rd(1, d); chk("R6 still logged", d, mk(1, 0, 1, 0, 0, 16'h5));
    wr(0, 64'h04); wr(1, 0);
    ev(1, 0, 0, 0, 16'h0002, 48'hD100);
    chk("R6 enabled bit2", 64'(mce_req), 1);
    wr(1, 0);
    ev(1, 0, 0, 0, 16'h0003, 48'hD200);
    chk("R6 disabled bit3", 64'(mce_req), 0);
  endtask

  task automatic t_spec();
    logic [63:0] d;
    wr(0, 64'hFF); wr(1, 0);
    ev(1, 1, 1, 0, 16'h0077, 48'hE000);
    chk("R9 spec no mce", 64'(mce_req), 0);
    rd(1, d); chk("R9 spec logged", d, mk(1, 0, 1, 1, 1, 16'h77));
    ev(0, 0, 0, 0, 16'h0078, 48'hF000);
    rd(1, d); chk("R9 corr cannot replace", d, mk(1, 1, 1, 1, 1, 16'h77));
    ev(1, 1, 0, 0, 16'h0079, 48'hE000);
    chk("R9 demand mce", 64'(mce_req), 1);
    rd(1, d); chk("R9 demand replaces", d, mk(1, 1, 1, 1, 0, 16'h79));
    rd(2, d); chk("R9 addr", d, 64'hE000);
  endtask

  task automatic t_dual();
    logic [63:0] d;
    wr(1, 0);
    ev(0, 0, 0, 1, 16'h0012, 48'h0123);
    rd(1, d); chk("R8 dual", d, mk(1, 1, 0, 0, 0, 16'h12));
  endtask

  task automatic t_collide();
    logic [63:0] d;
    wr(0, 64'hFF);
    @(negedge clk);
    reg_sel = 1; reg_wdata = 0; reg_we = 1;
    err_uc = 1; err_pcc = 0; err_spec = 0; err_dual = 0; err_code = 16'h31; err_addr = 48'h4440;
    err_valid = 1;
    @(negedge clk);
    reg_we = 0; err_valid = 0;
    rd(1, d); chk("R10 write wins", d, 0);
    chk("R10 no mce yet", 64'(mce_req), 0);
    @(negedge clk);
    rd(1, d); chk("R10 logged next", d, mk(1, 0, 1, 0, 0, 16'h31));
    rd(2, d); chk("R10 R7 addr", d, 64'h4440);
    chk("R10 R11 mce late", 64'(mce_req), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_corr();
    t_uclock();
    t_disabled();
    t_spec();
    t_dual();
    t_collide();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog act=hung exp=done");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end
endmodule